// File: doc/BRIEF.md
# Bidirectional Latch/Register Bus Transceiver

This block joins two 18-bit ports, A and B, with one storage element per bit in each direction. The A-to-B path and the B-to-A path each have a latch-enable level, a transfer clock and an output enable. Each path runs in one of three modes. When latch enable is high the path is transparent. When latch enable is low, a low-to-high transition of the path's transfer clock captures the data. When latch enable is low and the transfer clock holds a steady level, the stored word is kept. The two paths share no state.

No real tri-state pads are used. Each port has an input word and an input-valid flag that says an external driver is active. It also has an output word and a per-bit output-enable vector. A bus-hold register on each port keeps the last value that was actually on the wire. That value came either from the external driver or from the block's own output. When nothing drives the port, the held value stands in for the input. All logic runs on one system clock with a synchronous active-low reset. The transfer clocks and latch enables are sampled levels, and their edges are found by comparing each level with the one from the previous cycle.

Top module: `xcvr_top`

## Requirements
- R1: While `le_ab` is 1 and A is externally driven (`a_drv`=1), `b_out` equals `a_in` in the same cycle, with no register on the way.
- R2: While `le_ab` is 0, a rise of `ck_ab` (0 in the previous cycle, 1 now) captures the A value. That value appears on `b_out` from the next cycle onward.
- R3: While `le_ab` is 0 and `ck_ab` shows no rise, the stored A-to-B word does not change. This holds when `ck_ab` stays high, stays low or falls, and whatever `a_in` does.
- R4: When `le_ab` falls, the word present in the last cycle it was high is kept. It stays until the next `ck_ab` rise, whether `ck_ab` was high or low when `le_ab` fell.
- R5: The A-to-B enable is active high. `b_oe` is all ones when `oe_ab` is 1 and all zeros when it is 0.
- R6: The B-to-A enable is active low. `a_oe` is all ones when `oe_ba_n` is 0 and all zeros when it is 1. The environment must never have both ports' outputs enabled at once.
- R7: The B-to-A path follows R1 to R4 with `b_in`, `le_ba` and `ck_ba` on `a_out`. Activity on one path never changes the other path's stored word.
- R8: A port with `x_drv`=0 presents its last driven value, whether that came from an external driver or from the block's own enabled output. That held value is what the port feeds to its path, and `x_in` is ignored.
- R9: Synchronous reset (`rst_n`=0 at a clock edge) clears both stored words and both held port values to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| a_in | input | 18 | Value driven onto port A from outside |
| a_drv | input | 1 | 1 while an external driver is active on port A |
| b_in | input | 18 | Value driven onto port B from outside |
| b_drv | input | 1 | 1 while an external driver is active on port B |
| le_ab | input | 1 | A-to-B latch enable, 1 = transparent |
| ck_ab | input | 1 | A-to-B transfer clock level (rise captures) |
| oe_ab | input | 1 | B output enable, active high |
| le_ba | input | 1 | B-to-A latch enable, 1 = transparent |
| ck_ba | input | 1 | B-to-A transfer clock level (rise captures) |
| oe_ba_n | input | 1 | A output enable, active low |
| a_out | output | 18 | Value the block presents on port A |
| a_oe | output | 18 | Per-bit drive enable for port A |
| b_out | output | 18 | Value the block presents on port B |
| b_oe | output | 18 | Per-bit drive enable for port B |

## Verification
Transparent data and both output-enable vectors are combinational, so they are due in the same cycle as the stimulus. A transfer-clock rise or a change of a port's driven value takes effect one system clock later, because it passes through exactly one register (the stored word or the bus-hold register). The bench changes inputs on the falling clock edge. It checks same-cycle results one time step later, before the next rising edge. It checks registered results at the next falling edge, after exactly one rising edge. It adds extra idle cycles only where it is checking that something stays unchanged.

// File: rtl/xcvr_pkg.sv
// Package: shared types for the bidirectional transceiver.
// Assumes nothing beyond standard SystemVerilog.
package xcvr_pkg;

    // Storage behaviour selected for one path in a given cycle
    typedef enum logic [1:0] {
        MODE_KEEP = 2'd0,   // latch enable low, no clock rise: hold
        MODE_EDGE = 2'd1,   // latch enable low, clock rose: capture
        MODE_PASS = 2'd2    // latch enable high: follow input
    } path_mode_e;

endpackage

// File: rtl/xcvr_bushold.sv
// Module: xcvr_bushold
// Models the wire of one port. It remembers the last value actually driven
// on the wire, by an external driver or by the block's own output, and
// presents that value when nothing drives the port.
// Assumes the external driver and the own output are never active together
// (the environment avoids contention). Synchronous active-low reset.
module xcvr_bushold #(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] ext_val,
    input  logic         ext_en,
    input  logic [W-1:0] own_val,
    input  logic         own_en,
    output logic [W-1:0] port_val
);

    logic [W-1:0] held_q;

    // Remember whatever was last driven onto the wire
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= '0;
        end else if (ext_en) begin
            held_q <= ext_val;
        end else if (own_en) begin
            held_q <= own_val;
        end
    end

    // Value the port feeds inward: live driver, otherwise the held level
    always_comb begin
        port_val = ext_en ? ext_val : held_q;
    end

endmodule

// File: rtl/xcvr_path.sv
// Module: xcvr_path
// One direction of the transceiver. Its storage word acts as a latch or a
// flop depending on the latch-enable level. The transfer clock is a sampled
// level, and a rise is seen when it is 1 now and was 0 in the previous
// system cycle. OE_LOW selects the output-enable polarity.
// Assumes le and ck are synchronous to clk. Synchronous active-low reset
// clears the storage word. The clock-history flop is not reset, so an edge
// is judged against the last sampled level.
module xcvr_path
    import xcvr_pkg::*;
#(
    parameter int W      = 18,
    parameter bit OE_LOW = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    input  logic         le,
    input  logic         ck,
    input  logic         oe_raw,
    output logic [W-1:0] dout,
    output logic [W-1:0] oe_vec
);

    logic [W-1:0] store_q;
    logic         ck_prev_q;
    logic         ck_rise;
    logic         oe_act;
    path_mode_e   mode;

    // Track the transfer clock level from the previous cycle
    always_ff @(posedge clk) begin
        ck_prev_q <= ck;
    end

    // Find a rise of the transfer clock
    always_comb begin
        ck_rise = ck & ~ck_prev_q;
    end

    // Choose the storage behaviour for this cycle
    always_comb begin
        if (le) begin
            mode = MODE_PASS;
        end else if (ck_rise) begin
            mode = MODE_EDGE;
        end else begin
            mode = MODE_KEEP;
        end
    end

    // Update the storage word according to the mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            store_q <= '0;
        end else begin
            case (mode)
                MODE_PASS: store_q <= din;
                MODE_EDGE: store_q <= din;
                default:   store_q <= store_q;
            endcase
        end
    end

    // Output value: bypass in transparent mode, stored word otherwise
    always_comb begin
        dout = (mode == MODE_PASS) ? din : store_q;
    end

    // Resolve the enable polarity chosen by the parameter
    generate
        if (OE_LOW) begin : g_oe_low
            assign oe_act = ~oe_raw;
        end else begin : g_oe_high
            assign oe_act = oe_raw;
        end
    endgenerate

    // Spread the enable across every bit
    always_comb begin
        oe_vec = {W{oe_act}};
    end

endmodule

// File: rtl/xcvr_top.sv
// Module: xcvr_top
// Two-port bus transceiver. Each port has a bus-hold wire model, and each
// direction has its own latch/flop path. The A-to-B enable is active high
// and the B-to-A enable is active low.
// Assumes all controls are synchronous to clk and that the two output
// enables are never active together. Synchronous active-low reset.
module xcvr_top #(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_in,
    input  logic         a_drv,
    input  logic [W-1:0] b_in,
    input  logic         b_drv,
    input  logic         le_ab,
    input  logic         ck_ab,
    input  logic         oe_ab,
    input  logic         le_ba,
    input  logic         ck_ba,
    input  logic         oe_ba_n,
    output logic [W-1:0] a_out,
    output logic [W-1:0] a_oe,
    output logic [W-1:0] b_out,
    output logic [W-1:0] b_oe
);

    logic [W-1:0] a_port;
    logic [W-1:0] b_port;

    // Port A wire model: held value fed to the A-to-B path
    xcvr_bushold #(.W(W)) u_hold_a (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_val  (a_in),
        .ext_en   (a_drv),
        .own_val  (a_out),
        .own_en   (a_oe[0]),
        .port_val (a_port)
    );

    // Port B wire model: held value fed to the B-to-A path
    xcvr_bushold #(.W(W)) u_hold_b (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_val  (b_in),
        .ext_en   (b_drv),
        .own_val  (b_out),
        .own_en   (b_oe[0]),
        .port_val (b_port)
    );

    // A-to-B direction, active-high enable
    xcvr_path #(.W(W), .OE_LOW(1'b0)) u_ab (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    (a_port),
        .le     (le_ab),
        .ck     (ck_ab),
        .oe_raw (oe_ab),
        .dout   (b_out),
        .oe_vec (b_oe)
    );

    // B-to-A direction, active-low enable
    xcvr_path #(.W(W), .OE_LOW(1'b1)) u_ba (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    (b_port),
        .le     (le_ba),
        .ck     (ck_ba),
        .oe_raw (oe_ba_n),
        .dout   (a_out),
        .oe_vec (a_oe)
    );

endmodule

// File: rtl/xcvr_checker.sv
// Module: xcvr_checker
// Properties over the transceiver ports, attached to xcvr_top by bind.
// Assumes the same clock and synchronous active-low reset as the top.
module xcvr_checker #(
    parameter int W = 18
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] a_in,
    input logic         a_drv,
    input logic [W-1:0] b_in,
    input logic         b_drv,
    input logic         le_ab,
    input logic         ck_ab,
    input logic         oe_ab,
    input logic         le_ba,
    input logic         ck_ba,
    input logic         oe_ba_n,
    input logic [W-1:0] a_out,
    input logic [W-1:0] a_oe,
    input logic [W-1:0] b_out,
    input logic [W-1:0] b_oe
);

    assert_ab_transparent_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (le_ab && a_drv) |-> (b_out == a_in));

    assert_ab_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!le_ab && $rose(ck_ab) && a_drv) |=> (le_ab || b_out == $past(a_in)));

    assert_ab_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!le_ab && !$rose(ck_ab)) |=> (le_ab || $stable(b_out)));

    assert_ab_le_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(le_ab) && $past(rst_n)) |-> (b_out == $past(b_out)));

    assert_b_oe_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        oe_ab |-> (b_oe == {W{1'b1}}));

    assert_b_oe_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_ab |-> (b_oe == '0));

    assert_a_oe_pol_R6: assert property (@(posedge clk) disable iff (!rst_n)
        oe_ba_n |-> (a_oe == '0));

    assert_no_contention_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(oe_ab && !oe_ba_n));

    assert_ba_transparent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (le_ba && b_drv) |-> (a_out == b_in));

    assert_ba_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!le_ba && $rose(ck_ba) && b_drv) |=> (le_ba || a_out == $past(b_in)));

    assert_ba_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!le_ba && !$rose(ck_ba)) |=> (le_ba || $stable(a_out)));

    assert_reset_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(rst_n) && !le_ab) |-> (b_out == '0));

endmodule

bind xcvr_top xcvr_checker #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .a_in    (a_in),
    .a_drv   (a_drv),
    .b_in    (b_in),
    .b_drv   (b_drv),
    .le_ab   (le_ab),
    .ck_ab   (ck_ab),
    .oe_ab   (oe_ab),
    .le_ba   (le_ba),
    .ck_ba   (ck_ba),
    .oe_ba_n (oe_ba_n),
    .a_out   (a_out),
    .a_oe    (a_oe),
    .b_out   (b_out),
    .b_oe    (b_oe)
);

// File: tb/sim_xcvr_top.sv
// Directed bench for xcvr_top. Inputs change on the falling edge, and
// results are sampled away from the rising edge.
module sim_xcvr_top;
    localparam int W = 18;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic         a_drv = 1'b0, b_drv = 1'b0;
    logic         le_ab = 1'b0, ck_ab = 1'b0, oe_ab = 1'b1;
    logic         le_ba = 1'b0, ck_ba = 1'b0, oe_ba_n = 1'b1;
    logic [W-1:0] a_out, a_oe, b_out, b_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    xcvr_top #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .a_in(a_in), .a_drv(a_drv),
        .b_in(b_in), .b_drv(b_drv), .le_ab(le_ab), .ck_ab(ck_ab),
        .oe_ab(oe_ab), .le_ba(le_ba), .ck_ba(ck_ba), .oe_ba_n(oe_ba_n),
        .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        #1;
        chk("R9 b_out after reset", b_out, '0);
        chk("R5 b_oe with oe_ab=1", b_oe, '1);
        oe_ab = 1'b0; oe_ba_n = 1'b0;
        #1;
        chk("R9 a_out after reset", a_out, '0);
        chk("R6 a_oe with oe_ba_n=0", a_oe, '1);
        oe_ba_n = 1'b1; oe_ab = 1'b1;
    endtask

    task automatic t_transparent;
        a_drv = 1'b1; le_ab = 1'b1; a_in = 18'h2A5C3;
        #1; chk("R1 pass word 1", b_out, 18'h2A5C3);
        cyc(1);
        a_in = 18'h15A3C;
        #1; chk("R1 pass word 2", b_out, 18'h15A3C);
    endtask

    task automatic t_clocked;
        cyc(1);
        le_ab = 1'b0; a_in = 18'h0F0F0;   // le falls, ck low
        cyc(1); #1;
        chk("R4 le fall ck low keeps last pass word", b_out, 18'h15A3C);
        ck_ab = 1'b1;
        cyc(1); #1;
        chk("R2 rise captures", b_out, 18'h0F0F0);
        a_in = 18'h33333;
        cyc(2); #1;
        chk("R3 ck steady high keeps", b_out, 18'h0F0F0);
        ck_ab = 1'b0;
        cyc(2); #1;
        chk("R3 ck fall keeps", b_out, 18'h0F0F0);
        ck_ab = 1'b1;
        cyc(1); #1;
        chk("R2 second rise captures", b_out, 18'h33333);
    endtask

    task automatic t_le_fall_ck_high;
        ck_ab = 1'b1; le_ab = 1'b1; a_in = 18'h1ABCD;
        cyc(1);
        le_ab = 1'b0; a_in = 18'h22222;
        cyc(1); #1;
        chk("R4 le fall ck high keeps", b_out, 18'h1ABCD);
        cyc(2); #1;
        chk("R4 held until rise", b_out, 18'h1ABCD);
        ck_ab = 1'b0;
        cyc(1);
        ck_ab = 1'b1;
        cyc(1); #1;
        chk("R4 next rise loads", b_out, 18'h22222);
    endtask

    task automatic t_enables;
        oe_ab = 1'b0;
        #1; chk("R5 b_oe off", b_oe, '0);
        oe_ab = 1'b1;
        #1; chk("R5 b_oe on", b_oe, '1);
        chk("R6 a_oe off with oe_ba_n=1", a_oe, '0);
    endtask

    task automatic t_ba_path;
        logic [W-1:0] kept_b;
        kept_b = b_out;
        oe_ab = 1'b0; oe_ba_n = 1'b0;
        b_drv = 1'b1; le_ba = 1'b1; b_in = 18'h3C3C3;
        #1; chk("R7 B-to-A pass", a_out, 18'h3C3C3);
        cyc(1);
        le_ba = 1'b0; b_in = 18'h05555;
        cyc(1); #1;
        chk("R7 B-to-A keeps after le fall", a_out, 18'h3C3C3);
        ck_ba = 1'b1;
        cyc(1); #1;
        chk("R7 B-to-A rise captures", a_out, 18'h05555);
        ck_ab = 1'b0; a_in = 18'h3FFFF;
        cyc(1); ck_ab = 1'b1;
        cyc(1); #1;
        chk("R7 A-side capture leaves a_out", a_out, 18'h05555);
        oe_ba_n = 1'b1; oe_ab = 1'b1;
        #1; chk("R7 A-to-B loaded independently", b_out, 18'h3FFFF);
        if (kept_b == 18'h3FFFF) chk("R7 distinct words", kept_b, ~kept_b);
        ck_ba = 1'b0;
        b_in = 18'h11111;
        cyc(2); #1;
        oe_ab = 1'b0; oe_ba_n = 1'b0;
        #1; chk("R7 B-to-A kept while ck falls", a_out, 18'h05555);
        oe_ba_n = 1'b1; oe_ab = 1'b1;
    endtask

    task automatic t_bushold;
        b_drv = 1'b0;
        le_ab = 1'b1; a_drv = 1'b1; a_in = 18'h2468A;
        cyc(1);
        a_drv = 1'b0; a_in = 18'h13579;
        #1; chk("R8 A held external value, a_in ignored", b_out, 18'h2468A);
        cyc(1); #1;
        chk("R8 A hold persists", b_out, 18'h2468A);
        oe_ab = 1'b0; oe_ba_n = 1'b0; le_ba = 1'b1;
        #1; chk("R8 B held own driven value", a_out, 18'h2468A);
        oe_ba_n = 1'b1; oe_ab = 1'b1;
    endtask

    initial begin
        t_reset();
        t_transparent();
        t_clocked();
        t_le_fall_ck_high();
        t_enables();
        t_ba_path();
        t_bushold();
        cyc(2);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule